// File: doc/BRIEF.md
# Dual-Frequency Phase-Stepped Burst Drive Generator

This block derives two square-wave drive signals from one master clock: a fundamental at one eighth of the clock rate and a second harmonic at one quarter of it. External low-pass filters turn the square waves into sinusoids. On a start strobe the block waits for the next fundamental period boundary. It then emits a gated burst that holds a fixed whole number of fundamental periods.

The harmonic output is shifted against the fundamental in steps of a quarter harmonic period. The shift comes from a tapped shift-register delay, and a 2-bit code selects the tap. The code is captured when a start is accepted and is held for the whole burst. A measurement sequence issues four bursts with codes 0, 2, 3 and 1, one after another. A one-cycle done pulse marks the end of each burst.

Top module: `dual_tone_burst_gen`

## Requirements
- R1: Inside a burst, `drv_1f` is a square wave with a period of DIV ticks. It is high for the first DIV/2 ticks of each period, counting from the tick where `burst_gate` rises.
- R2: The harmonic waveform has a period of DIV/2 ticks and is high for the first DIV/4 ticks of each period.
- R3: A captured phase code k (0..3) delays the whole gated harmonic burst by k×DIV/8 ticks, relative to the rise of `burst_gate`. The codes map as 0 = 0°, 1 = 90°, 2 = 180° and 3 = 270°. The delayed burst contains only whole harmonic pulses.
- R4: `burst_gate` rises 1 to DIV cycles after a start is accepted, on a fundamental period boundary. It stays high for exactly CYCLES×DIV ticks.
- R5: `drv_1f`, `drv_2f` and `burst_gate` are low whenever `busy` is low.
- R6: `busy` is high from the cycle after an accepted start until the done pulse. A start strobe seen while `busy` is high is ignored and does not begin another burst.
- R7: `phase_code` is sampled only when a start is accepted. Changes to it during a burst have no effect on the outputs.
- R8: `done` is high for exactly one cycle, 3×DIV/8 cycles after `burst_gate` falls. It rises in the same cycle that `busy` falls.
- R9: Asserting `rst_n` low immediately forces all outputs low, aborting any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request strobe, honoured only when idle |
| phase_code | input | 2 | Harmonic delay in quarter harmonic periods |
| busy | output | 1 | High while a burst is pending, running or draining |
| done | output | 1 | One-cycle end-of-burst pulse |
| drv_1f | output | 1 | Gated fundamental square wave |
| drv_2f | output | 1 | Gated, phase-delayed harmonic square wave |
| burst_gate | output | 1 | High during the fundamental burst window |

## Verification
The checker watches several rules on every cycle. It confirms that the outputs are quiet while idle, that the fundamental appears only inside the gate, and that the gate opens on a high fundamental level. It also checks that done is a single pulse that coincides with busy falling, and that the captured code is stable while busy. Other behaviour shows only in the bench's sweep of all four codes against all eight start offsets. This includes the exact tick-by-tick alignment of both waveforms and the harmonic delay per code. It also includes the burst length, the start latency, and the rejection of a start strobe issued mid-burst together with a changed code.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dfg_tick_ctr.sv
module dfg_tick_ctr #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap_o,
  output logic fund_o,
  output logic harm_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(DIV / 2);
  localparam logic [CW-1:0] QTR_C  = CW'(DIV / 4);

  logic [CW-1:0] tick_q;
  logic [CW-1:0] tick_nxt;

  always_comb begin
    wrap_o   = (tick_q == LAST_C);
    tick_nxt = wrap_o ? '0 : tick_q + 1'b1;
    fund_o   = (tick_q < HALF_C);
    harm_o   = ((tick_q % HALF_C) < QTR_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_nxt;
  end
endmodule

// File: rtl/dfg_burst_seq.sv
module dfg_burst_seq
  import dfg_pkg::*;
#(
  parameter int CYCLES = 150,
  parameter int DRAIN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wrap_i,
  output logic run_o,
  output logic busy_o,
  output logic done_o,
  output logic capture_o
);
  localparam int NCW = $clog2(CYCLES) + 1;
  localparam int DCW = $clog2(DRAIN) + 1;
  localparam logic [NCW-1:0] NLAST_C = NCW'(CYCLES - 1);
  localparam logic [DCW-1:0] DLAST_C = DCW'(DRAIN - 1);

  seq_state_t     state_q, state_nxt;
  logic [NCW-1:0] ncyc_q, ncyc_nxt;
  logic [DCW-1:0] dcnt_q, dcnt_nxt;
  logic           done_q, done_nxt;

  always_comb begin
    state_nxt = state_q;
    ncyc_nxt  = ncyc_q;
    dcnt_nxt  = dcnt_q;
    done_nxt  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_nxt = ST_ARM;
          capture_o = 1'b1;
        end
      end
      ST_ARM: begin
        if (wrap_i) begin
          state_nxt = ST_RUN;
          ncyc_nxt  = '0;
        end
      end
      ST_RUN: begin
        if (wrap_i) begin
          if (ncyc_q == NLAST_C) begin
            state_nxt = ST_DRAIN;
            ncyc_nxt  = '0;
            dcnt_nxt  = '0;
          end else begin
            ncyc_nxt = ncyc_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (dcnt_q == DLAST_C) begin
          state_nxt = ST_IDLE;
          done_nxt  = 1'b1;
        end else begin
          dcnt_nxt = dcnt_q + 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ncyc_q  <= '0;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      ncyc_q  <= ncyc_nxt;
      dcnt_q  <= dcnt_nxt;
      done_q  <= done_nxt;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/dfg_delay_line.sv
module dfg_delay_line #(
  parameter int STEP = 1,
  parameter int PW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_i,
  input  logic [PW-1:0] sel_i,
  output logic          q_o
);
  localparam int TAPS = 1 << PW;
  localparam int LEN  = (TAPS - 1) * STEP;

  logic [LEN-1:0] sr_q;
  logic           tap [TAPS];

  for (genvar i = 0; i < LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else        sr_q[i] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else        sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign tap[0] = d_i;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap[k] = sr_q[k*STEP-1];
  end

  assign q_o = tap[sel_i];
endmodule

// File: rtl/dual_tone_burst_gen.sv
module dual_tone_burst_gen #(
  parameter int DIV    = 8,
  parameter int CYCLES = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] phase_code,
  output logic       busy,
  output logic       done,
  output logic       drv_1f,
  output logic       drv_2f,
  output logic       burst_gate
);
  localparam int PW    = 2;
  localparam int STEP  = DIV / 8;
  localparam int DRAIN = ((1 << PW) - 1) * STEP;

  logic          wrap, fund, harm;
  logic          run, capture;
  logic [PW-1:0] code_q;
  logic          harm_gated;

  dfg_tick_ctr #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap_o(wrap),
    .fund_o(fund),
    .harm_o(harm)
  );

  dfg_burst_seq #(.CYCLES(CYCLES), .DRAIN(DRAIN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .wrap_i   (wrap),
    .run_o    (run),
    .busy_o   (busy),
    .done_o   (done),
    .capture_o(capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (capture) code_q <= phase_code;
  end

  assign harm_gated = run & harm;

  dfg_delay_line #(.STEP(STEP), .PW(PW)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (harm_gated),
    .sel_i(code_q),
    .q_o  (drv_2f)
  );

  assign drv_1f     = run & fund;
  assign burst_gate = run;
endmodule

// File: rtl/dfg_checker.sv
module dfg_checker #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          drv_1f,
  input logic          drv_2f,
  input logic          burst_gate,
  input logic [PW-1:0] code_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drv_1f && !drv_2f && !burst_gate)); // R5

  AST_FUND_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_1f |-> burst_gate); // R1

  AST_GATE_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_gate) |-> drv_1f); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

  AST_GATE_CLOSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_gate) |-> busy); // R6

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code_q)); // R7
endmodule

bind dual_tone_burst_gen dfg_checker #(.PW(2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .drv_1f    (drv_1f),
  .drv_2f    (drv_2f),
  .burst_gate(burst_gate),
  .code_q    (code_q)
);

// File: tb/sim_dual_tone_burst_gen.sv
module sim_dual_tone_burst_gen;
  localparam int DIV  = 8;
  localparam int CYC  = 150;
  localparam int LEN  = DIV * CYC;
  localparam int STEP = DIV / 8;
  localparam int DRN  = 3 * STEP;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] phase_code;
  logic       busy, done, drv_1f, drv_2f, burst_gate;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dual_tone_burst_gen #(.DIV(DIV), .CYCLES(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_code(phase_code),
    .busy(busy), .done(done), .drv_1f(drv_1f), .drv_2f(drv_2f),
    .burst_gate(burst_gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_burst(input int code, input int gap, input bit poke);
    int lat;
    int e1f, e2f, egate, edone, ebusy, quiet;
    repeat (gap) @(negedge clk);
    start = 1'b1;
    phase_code = 2'(code);
    @(negedge clk);
    start = 1'b0;
    phase_code = 2'(code ^ 1);               // R7: change after capture
    chk(busy === 1'b1, "R6 busy after start", int'(busy), 1);
    lat = 0;
    while (burst_gate !== 1'b1 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat >= 1 && lat <= DIV, "R4 start latency", lat, DIV);
    e1f = 0; e2f = 0; egate = 0; edone = 0; ebusy = 0;
    for (int j = 0; j < LEN + 10; j++) begin
      bit x1, x2, xg, xd, xb;
      int s;
      if (j > 0) @(negedge clk);
      s  = j - code * STEP;
      xg = (j < LEN);
      x1 = xg && ((j % DIV) < DIV / 2);                        // R1
      x2 = (s >= 0) && (s < LEN) && ((s % (DIV / 2)) < DIV / 4); // R2 R3
      xd = (j == LEN + DRN);
      xb = (j < LEN + DRN);
      if (drv_1f !== x1) e1f++;
      if (drv_2f !== x2) e2f++;
      if (burst_gate !== xg) egate++;
      if (done !== xd) edone++;
      if (busy !== xb) ebusy++;
      if (poke && j == 100) begin
        start = 1'b1;
        phase_code = 2'(code ^ 2);
      end
      if (j == 101) start = 1'b0;
    end
    chk(e1f == 0, "R1 fundamental waveform", e1f, 0);
    chk(e2f == 0, "R3 harmonic waveform/delay", e2f, 0);
    chk(egate == 0, "R4 gate length", egate, 0);
    chk(edone == 0, "R8 done pulse", edone, 0);
    chk(ebusy == 0, "R6 busy window", ebusy, 0);
    quiet = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (burst_gate !== 1'b0 || busy !== 1'b0 || drv_1f !== 1'b0 || drv_2f !== 1'b0) quiet++;
    end
    chk(quiet == 0, "R6 R5 ignored start / idle quiet", quiet, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seq [4];
    seq = '{0, 2, 3, 1};
    rst_n = 1'b0;
    start = 1'b0;
    phase_code = 2'd0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 reset busy", int'(busy), 0);
    chk(done === 1'b0, "R9 reset done", int'(done), 0);
    chk(burst_gate === 1'b0, "R9 reset gate", int'(burst_gate), 0);
    chk(drv_1f === 1'b0 && drv_2f === 1'b0, "R9 reset drives", int'(drv_1f | drv_2f), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(drv_1f === 1'b0 && drv_2f === 1'b0, "R5 idle drives", int'(drv_1f | drv_2f), 0);
    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < DIV; g++) begin
        run_burst(seq[c], g, (g % 2) == 1);
      end
    end
    start = 1'b1;
    phase_code = 2'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(burst_gate === 1'b0 && drv_1f === 1'b0 && drv_2f === 1'b0 && busy === 1'b0,
        "R9 async abort", int'(burst_gate | drv_1f | drv_2f | busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_burst(1, 3, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule